// File: doc/BRIEF.md
# Time-Multiplexed FIR Filter

This block is an 8-tap FIR filter that uses only two multipliers. Each input sample is processed over four fast-clock cycles, called phases. In every phase, a selector passes one group of delay-line taps to the multipliers. Each multiplier lane has a small coefficient ROM, addressed by the phase number, that supplies the matching coefficients. A multiply-accumulator adds the partial products over the four phases and writes the full-precision sum to a registered output.

Everything runs on one clock. A single-cycle strobe marks each new sample. The delay line moves only when a strobe is accepted. The accumulator starts from zero on the first phase of each sample, so no sum carries over from one output to the next. Registers follow the coefficient read, the multipliers and the accumulator, so that the clock rate stays high. The latency from an accepted strobe to its output is fixed.

Top module: `tdmfir`

## Requirements
- R1: After reset, `y_out` is 0 and `y_valid` is 0. The delay line holds zeros, so the first outputs see an all-zero history.
- R2: An accepted strobe shifts `x_in` into tap 0 and moves every older sample up by one tap, so tap k holds x(n-k). The delay line does not change on any other cycle.
- R3: The phase counter is set to 0 by an accepted strobe. It then advances by one per clock up to 3 and stops. In phase p, multiplier lane j multiplies tap p*2+j by coefficient p*2+j.
- R4: The accumulator is loaded with the phase-0 partial sum, not added to its old value. An output never contains any part of an earlier sample's sum.
- R5: `y_out` equals the sum over k = 0..7 of c_k·x(n-k), as a 35-bit signed two's-complement value, with no overflow or rounding. Coefficient k occupies bits [16k+15:16k] of the `COEFS` parameter.
- R6: `y_valid` is high for exactly one cycle per accepted sample. It rises on the 6th rising edge after the edge that samples the accepted strobe. `y_out` then holds that sample's result until the next output.
- R7: A strobe sampled fewer than 4 edges after the last accepted strobe is ignored. It does not shift the delay line, start phases or produce an output. A strobe exactly 4 edges later is accepted.
- R8: A unit impulse followed by zeros produces the eight coefficients in tap order on eight consecutive outputs.
- R9: Strobes at the minimum spacing of 4 cycles produce one correct output each, with no interference between neighbouring samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; 4 cycles per sample at the minimum spacing |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | One-cycle strobe that marks a new input sample |
| x_in | input | 16 | Signed input sample |
| y_out | output | 35 | Signed filter result, held between outputs |
| y_valid | output | 1 | One-cycle pulse when `y_out` is updated |

## Verification
Assertions check the following on every cycle:
- the delay line shifts only on an accepted strobe and otherwise holds;
- the phase counter starts at 0 and steps through its sequence;
- a strobe during a busy window never restarts the phases;
- the accumulator reloads on phase 0;
- each last-phase sum becomes a single output pulse.

The bench scenarios show what the per-cycle checks cannot. These are:
- the numeric result of the convolution, compared against a reference model in the bench;
- the pairing of taps with coefficients, shown by the impulse response;
- that ignored strobes do not disturb later outputs;
- the exact latency;
- the extreme-value sums.

// File: rtl/tdmfir_pkg.sv
package tdmfir_pkg;

  // Accumulator width that holds the sum of ntap full products without overflow.
  function automatic int acc_width(input int dw, input int cw, input int ntap);
    return dw + cw + $clog2(ntap);
  endfunction

  // Tap index served by a given lane during a given phase.
  function automatic int tap_index(input int phase, input int lane, input int tpp);
    return phase * tpp + lane;
  endfunction

  // Width of the phase counter.
  function automatic int phase_width(input int tdm);
    return (tdm > 1) ? $clog2(tdm) : 1;
  endfunction

endpackage

// File: rtl/tdmfir_delay_line.sv
module tdmfir_delay_line #(
  parameter int DW   = 16,
  parameter int NTAP = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic [DW-1:0]        din,
  output logic [NTAP*DW-1:0]   taps_flat
);

  logic [DW-1:0] tap_q [NTAP];

  always_ff @(posedge clk) begin
    if (rst)           tap_q[0] <= '0;
    else if (shift_en) tap_q[0] <= din;
  end

  for (genvar k = 1; k < NTAP; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)           tap_q[k] <= '0;
      else if (shift_en) tap_q[k] <= tap_q[k-1];
    end
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_flat
    assign taps_flat[k*DW +: DW] = tap_q[k];
  end

  // R2
  newest_tap_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> tap_q[0] == $past(din));

  // R2
  ripple_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> tap_q[NTAP-1] == $past(tap_q[NTAP-2]));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(taps_flat));

endmodule

// File: rtl/tdmfir_phase_ctrl.sv
module tdmfir_phase_ctrl #(
  parameter int TDM = 4,
  localparam int PW = tdmfir_pkg::phase_width(TDM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  output logic          accept,
  output logic          active,
  output logic [PW-1:0] phase,
  output logic          first,
  output logic          last
);

  localparam logic [PW-1:0] LAST_PH = PW'(TDM - 1);

  assign last   = active && (phase == LAST_PH);
  assign first  = active && (phase == '0);
  assign accept = strobe && (!active || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (accept) begin
      active <= 1'b1;
      phase  <= '0;
    end else if (active) begin
      if (phase == LAST_PH) active <= 1'b0;
      else                  phase  <= phase + 1'b1;
    end
  end

  // R3
  start_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> active && phase == '0);

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    active && !last |=> active && phase == PW'($past(phase) + 1'b1));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    strobe && active && !last |=> phase != '0);

endmodule

// File: rtl/tdmfir_coef_rom.sv
module tdmfir_coef_rom #(
  parameter int CW   = 16,
  parameter int TDM  = 4,
  parameter int TPP  = 2,
  parameter int LANE = 0,
  parameter logic [TDM*TPP*CW-1:0] COEFS = '0,
  localparam int PW = tdmfir_pkg::phase_width(TDM)
) (
  input  logic          clk,
  input  logic [PW-1:0] addr,
  output logic [CW-1:0] dout
);

  logic [CW-1:0] rom [TDM];

  for (genvar p = 0; p < TDM; p++) begin : g_word
    assign rom[p] = COEFS[tdmfir_pkg::tap_index(p, LANE, TPP)*CW +: CW];
  end

  always_ff @(posedge clk) begin
    dout <= rom[addr];
  end

endmodule

// File: rtl/tdmfir_mac.sv
module tdmfir_mac #(
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int TPP = 2,
  parameter int AW  = 35
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic                 in_last,
  input  logic [TPP*DW-1:0]    x_flat,
  input  logic [TPP*CW-1:0]    c_flat,
  output logic signed [AW-1:0] y,
  output logic                 y_valid
);

  localparam int PRW = DW + CW;

  function automatic logic signed [PRW-1:0] mul_term(input logic signed [DW-1:0] a,
                                                     input logic signed [CW-1:0] b);
    logic signed [PRW-1:0] ea, eb;
    ea = PRW'(a);
    eb = PRW'(b);
    return ea * eb;
  endfunction

  function automatic logic signed [AW-1:0] widen(input logic signed [PRW-1:0] v);
    return AW'(v);
  endfunction

  logic signed [PRW-1:0] prod_q [TPP];
  logic                  vb, fb, lb;
  logic signed [AW-1:0]  acc_q;
  logic signed [AW-1:0]  lane_sum;
  logic signed [AW-1:0]  acc_next;
  logic                  acc_clear;
  logic                  out_fire;

  always_comb begin
    lane_sum = '0;
    for (int j = 0; j < TPP; j++) lane_sum = lane_sum + widen(prod_q[j]);
  end

  assign acc_clear = vb && fb;
  assign out_fire  = vb && lb;
  assign acc_next  = (acc_clear ? '0 : acc_q) + lane_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      vb <= 1'b0;
      fb <= 1'b0;
      lb <= 1'b0;
      for (int j = 0; j < TPP; j++) prod_q[j] <= '0;
      acc_q   <= '0;
      y       <= '0;
      y_valid <= 1'b0;
    end else begin
      vb <= in_valid;
      fb <= in_first;
      lb <= in_last;
      for (int j = 0; j < TPP; j++)
        prod_q[j] <= mul_term(x_flat[j*DW +: DW], c_flat[j*CW +: CW]);
      if (vb) acc_q <= acc_next;
      y_valid <= out_fire;
      if (out_fire) y <= acc_next;
    end
  end

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    acc_clear |=> acc_q == $past(lane_sum));

  // R6
  fire_chk: assert property (@(posedge clk) disable iff (rst)
    out_fire |=> y_valid && y == acc_q);

  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_fire |=> !y_valid && $stable(y));

  // R6
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid);

endmodule

// File: rtl/tdmfir.sv
module tdmfir #(
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int TDM = 4,
  parameter int TPP = 2,
  parameter logic [TDM*TPP*CW-1:0] COEFS = 128'h01FF_DCD8_0007_0019_8000_7FFF_F2B8_04B0,
  localparam int NTAP = TDM * TPP,
  localparam int AW   = tdmfir_pkg::acc_width(DW, CW, TDM * TPP),
  localparam int PW   = tdmfir_pkg::phase_width(TDM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_valid,
  input  logic signed [DW-1:0] x_in,
  output logic signed [AW-1:0] y_out,
  output logic                 y_valid
);

  logic          accept, active, first, last;
  logic [PW-1:0] phase;
  logic [NTAP*DW-1:0] taps_flat;
  logic [TPP*DW-1:0]  sel_x;
  logic [TPP*DW-1:0]  xa_q;
  logic [TPP*CW-1:0]  ca;
  logic               va_q, fa_q, la_q;

  tdmfir_phase_ctrl #(.TDM(TDM)) u_ctrl (
    .clk(clk), .rst(rst), .strobe(sample_valid), .accept(accept),
    .active(active), .phase(phase), .first(first), .last(last)
  );

  tdmfir_delay_line #(.DW(DW), .NTAP(NTAP)) u_line (
    .clk(clk), .rst(rst), .shift_en(accept), .din(x_in), .taps_flat(taps_flat)
  );

  // Tap group selection and matching coefficient ROM per lane.
  for (genvar j = 0; j < TPP; j++) begin : g_lane
    always_comb begin
      sel_x[j*DW +: DW] = taps_flat[tdmfir_pkg::tap_index(int'(phase), j, TPP)*DW +: DW];
    end

    tdmfir_coef_rom #(.CW(CW), .TDM(TDM), .TPP(TPP), .LANE(j), .COEFS(COEFS)) u_rom (
      .clk(clk), .addr(phase), .dout(ca[j*CW +: CW])
    );
  end

  // Operand register, aligned with the ROM read.
  always_ff @(posedge clk) begin
    if (rst) begin
      va_q <= 1'b0;
      fa_q <= 1'b0;
      la_q <= 1'b0;
      xa_q <= '0;
    end else begin
      va_q <= active;
      fa_q <= first;
      la_q <= last;
      xa_q <= sel_x;
    end
  end

  tdmfir_mac #(.DW(DW), .CW(CW), .TPP(TPP), .AW(AW)) u_mac (
    .clk(clk), .rst(rst), .in_valid(va_q), .in_first(fa_q), .in_last(la_q),
    .x_flat(xa_q), .c_flat(ca), .y(y_out), .y_valid(y_valid)
  );

  // R3
  operand_flow_chk: assert property (@(posedge clk) disable iff (rst)
    active |=> va_q && (fa_q == $past(phase == '0)));

endmodule

// File: tb/tdmfir_test.sv
module tdmfir_test;

  localparam int TDM = 4;
  localparam int NT  = 8;
  localparam int LAT = TDM + 2;
  localparam int BC [NT] = '{1200, -3400, 32767, -32768, 25, 7, -9000, 511};

  function automatic logic [NT*16-1:0] pack_coefs();
    logic [NT*16-1:0] v;
    for (int k = 0; k < NT; k++) v[k*16 +: 16] = 16'(BC[k]);
    return v;
  endfunction
  localparam logic [NT*16-1:0] BCOEF = pack_coefs();

  localparam int NV = 18;
  localparam int VX [NV] = '{1000, -2000, 32767, -32768, 4321, 0, -1, 15000, -15000,
                             77, 32767, 32767, -32768, -32768, 123, -456, 789, 5};
  localparam int VG [NV] = '{4, 5, 4, 6, 2, 4, 4, 7, 3, 4, 4, 4, 4, 1, 5, 4, 8, 4};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic signed [15:0] x_in = '0;
  logic signed [34:0] y_out;
  logic y_valid;

  tdmfir #(.COEFS(BCOEF)) uut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .x_in(x_in),
    .y_out(y_out), .y_valid(y_valid)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int edge_cnt = 0;
  bit done = 1'b0;

  longint hist [NT];
  longint exp_val [256];
  int     exp_edge [256];
  string  exp_tag [256];
  int wr = 0, rd = 0;
  int last_acc = -1;
  int n_acc = 0, n_out = 0;
  bit pending_ign = 1'b0;

  always @(posedge clk) edge_cnt++;

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Output monitor, away from the rising edge.
  always @(negedge clk) begin
    if (!rst && y_valid) begin
      n_out++;
      if (rd < wr) begin
        check(exp_tag[rd], longint'(y_out), exp_val[rd]);
        check("R6 latency", longint'(edge_cnt), longint'(exp_edge[rd]));
        rd++;
      end else begin
        check("R7 unexpected output", 1, 0);
      end
    end
  end

  // Drive one strobe at a falling edge; the bench model decides acceptance.
  task automatic strobe(input int xv, input string tag);
    int e;
    longint s;
    e = edge_cnt + 1;
    sample_valid = 1'b1;
    x_in = 16'(xv);
    if (last_acc < 0 || e - last_acc >= TDM) begin
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(xv);
      s = 0;
      for (int k = 0; k < NT; k++) s += longint'(BC[k]) * hist[k];
      exp_val[wr]  = s;
      exp_edge[wr] = e + LAT;
      exp_tag[wr]  = pending_ign ? "R7" : tag;
      pending_ign  = 1'b0;
      wr++;
      n_acc++;
      last_acc = e;
    end else begin
      pending_ign = 1'b1;
    end
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sample_valid = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NT; k++) hist[k] = 0;
    rd = wr;
    last_acc = -1;
    pending_ign = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 y_out", longint'(y_out), 0);
    check("R1 y_valid", longint'(y_valid), 0);

    // R8 / R3: impulse response reproduces coefficients in tap order
    strobe(1, "R3/R8");
    repeat (TDM - 1) @(negedge clk);
    for (int k = 1; k < NT; k++) begin
      strobe(0, "R3/R8");
      repeat (TDM - 1) @(negedge clk);
    end
    repeat (LAT + 2) @(negedge clk);

    // Vector table walk: R5 values, R9 minimum spacing, R7 early strobes
    for (int i = 0; i < NV; i++) begin
      strobe(VX[i], (i > 0 && VG[i-1] == TDM) ? "R9" : "R5");
      if (VG[i] > 1) repeat (VG[i] - 1) @(negedge clk);
    end
    repeat (LAT + 4) @(negedge clk);

    // R7: every accepted strobe gave exactly one output, ignored ones none
    check("R7 output count", longint'(n_out), longint'(n_acc));

    // Reset during processing drops the sample and clears history (R1)
    strobe(20000, "R1");
    @(negedge clk);
    do_reset();
    check("R1 y_valid after reset", longint'(y_valid), 0);
    repeat (LAT + 2) @(negedge clk);

    // R2 / R4: a full-scale sample then zeros; no sum carries between outputs
    strobe(32767, "R2/R4");
    repeat (TDM - 1) @(negedge clk);
    for (int k = 1; k < NT + 2; k++) begin
      strobe(0, "R2/R4");
      repeat (TDM - 1) @(negedge clk);
    end
    repeat (LAT + 2) @(negedge clk);

    // R5: extreme-magnitude history aligned with coefficient signs
    for (int k = 0; k < NT; k++) begin
      strobe((BC[NT-1-k] < 0) ? -32768 : 32767, "R5");
      repeat (TDM - 1) @(negedge clk);
    end
    repeat (LAT + 2) @(negedge clk);

    check("R6 all outputs seen", longint'(rd), longint'(wr));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule